// File: doc/BRIEF.md
# Interrupt Event Notification Escalator

This block turns two interrupt sources into status bits that software can read, and into notification requests for a downstream cell generator. The first source is an asynchronous PHY interrupt pin. The pin is synchronized and acts on its rising edge. The second source is a single-cycle address range error strobe from the receive path. A third status bit records dropped transmit cells, but it never raises a notification.

Each notification request carries a source identifier. It is offered on a valid/ready handshake and stays pending until it is accepted. If software leaves an interrupt latched, the block escalates. After a long first interval it sets a read-only timeout flag and requests again. It then keeps requesting at a shorter repeat period until the status bit is cleared. Both intervals are parameters counted in clock cycles.

Top module: `irq_escalator`

## Requirements
- R1: A rising edge on `phy_irq_in`, after a two-flop synchronizer, sets status bit 0 at the third rising clock edge after the pin goes high. A level that stays high after the bit is cleared does not set it again until the pin has gone low and risen once more.
- R2: A cycle with `aerr_evt` high sets status bit 1 at the next clock edge.
- R3: The status register is at `reg_addr` 0. A write with bit 0 or bit 1 of `reg_wdata` at one clears that status bit, and a zero in that position leaves it unchanged. If a clear and a new event for the same source fall in the same cycle, the bit ends up set and counts as a new event.
- R4: The mask register is at `reg_addr` 1. Bit 0 masks PHY and bit 1 masks address error, both reset to zero, and the register reads back what was written. A notification request is raised only for a source whose mask bit is one in the cycle the event or timeout happens.
- R5: While a status bit is set, further events from that source raise no request and do not restart its timer.
- R6: When a status bit has stayed set for `FIRST_TO_CYC` cycles, the matching timeout bit at `reg_addr` 2 (bit 0 PHY, bit 1 address error) is set. A request is raised at that point if the source is unmasked.
- R7: After the first timeout, a request is raised every `REPEAT_CYC` cycles until the status bit is cleared.
- R8: The timeout register is read-only, so writes to address 2 have no effect. A timeout bit returns to zero on the edge where its status bit is cleared.
- R9: `ntf_valid` stays high until `ntf_ready` is seen. `ntf_src` is 0 for PHY and 1 for address error. PHY wins when both are pending, and no pending request is lost.
- R10: A `cell_drop` pulse sets status bit 2. This bit never raises a notification. It is cleared only by a status write with bit 2 at zero, and a pulse in the same cycle as that write leaves it set.
- R11: After reset, all registers read zero and `ntf_valid` is low. Address 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_irq_in | input | 1 | Asynchronous PHY interrupt pin |
| aerr_evt | input | 1 | Address range error strobe |
| cell_drop | input | 1 | Transmit cell dropped strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 status, 1 mask, 2 timeout) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ntf_valid | output | 1 | Notification request pending |
| ntf_src | output | 1 | Source of the offered request |
| ntf_ready | input | 1 | Consumer accepts the offered request |

## Verification
The bench targets six corner cases.

- A clear in the same cycle as a new event: a design that lets the clear win loses an interrupt.
- A PHY level held high across a clear: a design that detects levels instead of edges re-latches in a loop.
- Both sources pending while the consumer stalls: a wrong priority or a dropped pending bit shows up as a wrong `ntf_src` or a missing request.
- A timed-out source, where exactly one request per repeat period must appear, even while fresh events arrive. A design that restarts its timer on ignored events, or fires more than once, gives the wrong count.
- The timeout flag's self-clear.
- The inverted clear rule of the cell-drop bit.

// File: rtl/iee_pkg.sv
// Shared constants for the interrupt event notification escalator.
// Assumes exactly two notifying sources with fixed indices.
package iee_pkg;
    localparam int NUM_SRC  = 2;
    localparam int SRC_PHY  = 0;
    localparam int SRC_AERR = 1;
    localparam int DROP_BIT = 2;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_TMO    = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/iee_sync_edge.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes the input may change at any time relative to clk.
module iee_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Resolve metastability and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    // R1
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/iee_src_track.sv
// Per-source tracker: status latch, elapsed-time counter, timeout flag
// and pending notification bit. Assumes FIRST_TO_CYC and REPEAT_CYC >= 1.
module iee_src_track #(
    parameter int FIRST_TO_CYC = 2_500_000,
    parameter int REPEAT_CYC   = 1_200_000,
    localparam int MAX_CYC     = (FIRST_TO_CYC > REPEAT_CYC) ? FIRST_TO_CYC : REPEAT_CYC,
    localparam int CNT_W       = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic mask_i,
    input  logic grant_i,
    output logic stat_o,
    output logic tmo_o,
    output logic pend_o
);
    logic             stat_q, tmo_q, pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             new_evt, fire;

    // Clear is applied before the event, so a coincident event is latched.
    assign new_evt = evt_i & (~stat_q | clr_i);
    assign limit   = tmo_q ? CNT_W'(REPEAT_CYC - 1) : CNT_W'(FIRST_TO_CYC - 1);
    assign fire    = stat_q & ~clr_i & (cnt_q == limit);

    // Status latch and timeout phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            stat_q <= new_evt | (stat_q & ~clr_i);
            if (clr_i)     tmo_q <= 1'b0;
            else if (fire) tmo_q <= 1'b1;
        end
    end

    // Elapsed-time counter, restarted on latch and on every fire.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (new_evt || !stat_q || clr_i || fire) cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
    end

    // Pending request held until granted; fresh requests merge into it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~grant_i) | (mask_i & (new_evt | fire));
    end

    assign stat_o = stat_q;
    assign tmo_o  = tmo_q;
    assign pend_o = pend_q;

    // R8
    tmo_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> stat_q);
    // R6
    tmo_rise_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_q) |-> $past(stat_q));
    // R4
    pend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(mask_i));
endmodule

// File: rtl/iee_ntf_arb.sv
// Fixed-priority selector for pending notifications; lowest index wins.
// Assumes requests stay asserted until their grant.
module iee_ntf_arb #(
    parameter int N     = 2,
    localparam int SRC_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [SRC_W-1:0] src_o,
    output logic [N-1:0]     gnt_o
);
    // Pick the lowest pending index and grant it on ready.
    always_comb begin
        logic found;
        found = 1'b0;
        src_o = '0;
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                found    = 1'b1;
                src_o    = SRC_W'(i);
                gnt_o[i] = ready_i;
            end
        end
    end

    assign valid_o = |req_i;

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o);
    // R9
    top_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i && src_o == '0 |=> valid_o && src_o == '0);
endmodule

// File: rtl/irq_escalator.sv
// Interrupt event notification escalator: latches interrupt sources,
// exposes status/mask/timeout registers, and requests notifications with
// timed re-notification of unserviced interrupts.
// Assumes DATA_W >= 3 and FIRST_TO_CYC, REPEAT_CYC >= 1.
module irq_escalator #(
    parameter int FIRST_TO_CYC = 2_500_000,
    parameter int REPEAT_CYC   = 1_200_000,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_irq_in,
    input  logic              aerr_evt,
    input  logic              cell_drop,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ntf_valid,
    output logic              ntf_src,
    input  logic              ntf_ready
);
    import iee_pkg::*;

    logic [NUM_SRC-1:0] evt, clr, mask_q, stat, tmo, pend, gnt;
    logic               phy_rise, drop_q, wr_status, wr_mask;

    assign wr_status = reg_wr && (reg_addr_e'(reg_addr) == RA_STATUS);
    assign wr_mask   = reg_wr && (reg_addr_e'(reg_addr) == RA_MASK);

    iee_sync_edge u_phy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (phy_irq_in),
        .rise_o  (phy_rise)
    );

    assign evt[SRC_PHY]  = phy_rise;
    assign evt[SRC_AERR] = aerr_evt;
    assign clr           = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        iee_src_track #(
            .FIRST_TO_CYC (FIRST_TO_CYC),
            .REPEAT_CYC   (REPEAT_CYC)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt[s]),
            .clr_i   (clr[s]),
            .mask_i  (mask_q[s]),
            .grant_i (gnt[s]),
            .stat_o  (stat[s]),
            .tmo_o   (tmo[s]),
            .pend_o  (pend[s])
        );
    end

    iee_ntf_arb #(.N(NUM_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pend),
        .ready_i (ntf_ready),
        .valid_o (ntf_valid),
        .src_o   (ntf_src),
        .gnt_o   (gnt)
    );

    // Mask register, written whole from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
    end

    // Cell-drop flag: write zero clears, a new drop sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else        drop_q <= cell_drop | (drop_q & ~(wr_status & ~reg_wdata[DROP_BIT]));
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_STATUS: begin
                reg_rdata[NUM_SRC-1:0] = stat;
                reg_rdata[DROP_BIT]    = drop_q;
            end
            RA_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
            RA_TMO:    reg_rdata[NUM_SRC-1:0] = tmo;
            default:   reg_rdata = '0;
        endcase
    end

    // R10
    drop_no_ntf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ntf_valid) |-> $past(|(evt & mask_q)) || $past(|(stat & mask_q)));
endmodule

// File: tb/tb_irq_escalator.sv
module tb_irq_escalator;
    localparam int CLK_P  = 10;
    localparam int FIRST  = 20;
    localparam int REPEAT = 7;

    logic       clk = 0, rst_n = 0;
    logic       phy_irq_in = 0, aerr_evt = 0, cell_drop = 0, reg_wr = 0, ntf_ready = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       ntf_valid, ntf_src;

    int total = 0, bad = 0;
    int hs0 = 0, hs1 = 0;
    bit started = 0;

    // behavioural model state
    int m_stat[2], m_tmo[2], m_pend[2], m_age[2], m_due[2];
    int m_mask = 0, m_drop = 0;
    int ph[$];

    irq_escalator #(.FIRST_TO_CYC(FIRST), .REPEAT_CYC(REPEAT)) dut (
        .clk(clk), .rst_n(rst_n), .phy_irq_in(phy_irq_in), .aerr_evt(aerr_evt),
        .cell_drop(cell_drop), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ntf_valid(ntf_valid),
        .ntf_src(ntf_src), .ntf_ready(ntf_ready));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: advance one clock using inputs held since last negedge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_stat[s] = 0; m_tmo[s] = 0; m_pend[s] = 0; m_age[s] = 0; m_due[s] = 0;
            end
            m_mask = 0; m_drop = 0;
            ph = '{0, 0, 0};
        end else begin
            int ev[2];
            int clrv[2];
            bit wst;
            ev[0] = (ph[1] == 1 && ph[2] == 0) ? 1 : 0;
            ev[1] = int'(aerr_evt);
            ph.push_front(int'(phy_irq_in));
            void'(ph.pop_back());
            if (ntf_ready) begin
                if (m_pend[0] != 0) m_pend[0] = 0;
                else if (m_pend[1] != 0) m_pend[1] = 0;
            end
            wst = reg_wr && reg_addr == 2'd0;
            for (int s = 0; s < 2; s++) begin
                bit raise;
                raise = 0;
                clrv[s] = (wst && reg_wdata[s]) ? 1 : 0;
                if (m_stat[s] != 0 && clrv[s] == 0) begin
                    m_age[s]++;
                    if (m_age[s] == m_due[s]) begin
                        m_tmo[s] = 1; raise = 1; m_due[s] += REPEAT;
                    end
                end
                if (clrv[s] != 0) begin m_stat[s] = 0; m_tmo[s] = 0; end
                if (ev[s] != 0 && m_stat[s] == 0) begin
                    m_stat[s] = 1; m_tmo[s] = 0; m_age[s] = 0; m_due[s] = FIRST; raise = 1;
                end
                if (raise && ((m_mask >> s) & 1) != 0) m_pend[s] = 1;
            end
            if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata[1:0]);
            if (wst && !reg_wdata[2]) m_drop = 0;
            if (cell_drop) m_drop = 1;
        end
    end

    function automatic int m_read(input int a);
        case (a)
            0: return m_stat[0] | (m_stat[1] << 1) | (m_drop << 2);
            1: return m_mask;
            2: return m_tmo[0] | (m_tmo[1] << 1);
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison against the model, a quarter period after negedge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (started && rst_n) begin
            int ev_v, ev_s;
            ev_v = (m_pend[0] | m_pend[1]);
            ev_s = (m_pend[0] != 0) ? 0 : 1;
            chk(int'(ntf_valid) == ev_v, "R9 valid", int'(ntf_valid), ev_v);
            if (ev_v != 0) chk(int'(ntf_src) == ev_s, "R9 src", int'(ntf_src), ev_s);
            case (reg_addr)
                2'd0: chk(int'(reg_rdata) == m_read(0), "R3 status", int'(reg_rdata), m_read(0));
                2'd1: chk(int'(reg_rdata) == m_read(1), "R4 mask", int'(reg_rdata), m_read(1));
                2'd2: chk(int'(reg_rdata) == m_read(2), "R8 timeout", int'(reg_rdata), m_read(2));
                default: chk(reg_rdata == 0, "R11 addr3", int'(reg_rdata), 0);
            endcase
            if (ntf_valid && ntf_ready) begin
                if (ntf_src) hs1++; else hs0++;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    endtask

    task automatic pulse_aerr();
        @(negedge clk); aerr_evt = 1;
        @(negedge clk); aerr_evt = 0;
    endtask

    task automatic pulse_phy();
        @(negedge clk); phy_irq_in = 1;
        cyc(3); phy_irq_in = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1;
        started = 1;
        // R11 reset state
        rd(0, 0, "R11"); rd(1, 0, "R11"); rd(2, 0, "R11"); rd(3, 0, "R11");
        chk(ntf_valid == 0, "R11 valid", int'(ntf_valid), 0);

        // R4 mask readback
        wr(1, 8'h03); rd(1, 3, "R4");
        ntf_ready = 1;

        // R1 edge latches, held level does not re-trigger after clear
        @(negedge clk); phy_irq_in = 1;
        cyc(4); rd(0, 1, "R1");
        wr(0, 8'h01); rd(0, 0, "R3");
        cyc(5); rd(0, 0, "R1");
        phy_irq_in = 0;
        cyc(3);

        // R2 and R9 priority under stall
        ntf_ready = 0;
        pulse_aerr();
        rd(0, 2, "R2");
        pulse_phy();
        cyc(3);
        chk(ntf_valid == 1 && ntf_src == 0, "R9 phy first", int'(ntf_src), 0);
        ntf_ready = 1;
        @(negedge clk); #1;
        chk(ntf_valid == 1 && ntf_src == 1, "R9 aerr kept", int'(ntf_src), 1);
        @(negedge clk); #1;
        chk(ntf_valid == 0, "R9 drained", int'(ntf_valid), 0);

        // R6 timeout, R8 read-only and self-clear
        cyc(FIRST + 2);
        rd(2, 3, "R6");
        wr(2, 8'h00); rd(2, 3, "R8");
        wr(0, 8'h02); rd(2, 1, "R8"); rd(0, 1, "R3");

        // R7 repeat cadence, R5 fresh events ignored while set
        @(negedge clk); hs0 = 0;
        fork
            cyc(3 * REPEAT - 1);
            begin cyc(3); pulse_phy(); end
        join
        @(negedge clk); #(CLK_P/2);
        chk(hs0 == 3, "R5 R7 repeats", hs0, 3);
        wr(0, 8'h01); rd(2, 0, "R8"); rd(0, 0, "R8");

        // R3 clear and event in the same cycle
        pulse_aerr(); cyc(2);
        @(negedge clk);
        reg_wr = 1; reg_addr = 0; reg_wdata = 8'h02; aerr_evt = 1;
        @(negedge clk);
        reg_wr = 0; aerr_evt = 0;
        rd(0, 2, "R3"); rd(2, 0, "R3");

        // R4 masked source raises nothing
        wr(1, 8'h00); wr(0, 8'h02); cyc(3);
        pulse_aerr(); cyc(3);
        chk(ntf_valid == 0, "R4 masked", int'(ntf_valid), 0);
        rd(0, 2, "R4");

        // R10 cell drop bit
        @(negedge clk); cell_drop = 1;
        @(negedge clk); cell_drop = 0;
        rd(0, 6, "R10");
        chk(ntf_valid == 0, "R10 no ntf", int'(ntf_valid), 0);
        wr(0, 8'h04); rd(0, 6, "R10");
        @(negedge clk);
        reg_wr = 1; reg_addr = 0; reg_wdata = 8'h00; cell_drop = 1;
        @(negedge clk);
        reg_wr = 0; cell_drop = 0;
        rd(0, 6, "R10");
        wr(0, 8'h00); rd(0, 2, "R10");
        wr(0, 8'h03);

        // mixed stimulus, checked cycle by cycle against the model
        wr(1, 8'h03);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) phy_irq_in = ~phy_irq_in;
            aerr_evt  = ($urandom_range(0, 30) == 0);
            cell_drop = ($urandom_range(0, 60) == 0);
            ntf_ready = ($urandom_range(0, 2) != 0);
            reg_wr    = ($urandom_range(0, 40) == 0);
            reg_addr  = 2'($urandom_range(0, 3));
            reg_wdata = 8'($urandom_range(0, 255));
        end
        @(negedge clk); reg_wr = 0; aerr_evt = 0; cell_drop = 0;
        cyc(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule